// File: doc/BRIEF.md
# Snooping MESI Line State Controller

This block holds the coherence state (modified, exclusive, shared or invalid) of every tracked cache line in every cache of a small multiprocessor model, together with one flag per line that says whether main memory holds current data. Each CPU presents one request at a time: load, load-for-ownership, store, atomic read-modify-write or evict. The controller serves one request per clock cycle, chosen in round-robin order. For each request it decides which bus message is needed (read, read-invalidate, invalidate or writeback), puts that message on a shared message output, and updates the requester, every peer cache and the memory flag in a single step.

A store to a line that the requester holds shared cannot complete at once. The controller broadcasts an invalidate, drops all peer copies, then stops serving requests until every other CPU has raised its acknowledge input. Only then does the requester move to modified. Ownership can pass directly from a cache that holds the line modified to a requester that issues a read-invalidate. In that case memory stays stale. Data storage, tag matching and interconnect timing are not modelled.

Top module: `mesi_ctrl`

## Requirements
- R1: After reset every line in every cache is invalid (code 0), every memory flag is 1 (current), req_done is zero and msg_valid is 0. The state codes are I=0, S=1, E=2, M=3. The request op codes are load=0, load-for-ownership=1, store=2, atomic=3, evict=4.
- R2: A load that misses, where no peer holds the line modified, sends a read message (kind 1). The requester ends in S, any peer in E is downgraded to S and memory stays current. A load that hits sends no message and changes nothing.
- R3: A load that misses on a line a peer holds in M sends a read. The peer drops to S, the requester becomes S and memory is marked current.
- R4: A load-for-ownership from I or S sends a read-invalidate (kind 2) and invalidates every peer. The requester becomes E and memory is left unchanged when no peer held M. From E or M it sends nothing.
- R5: A read-invalidate issued while a peer holds M hands ownership over. The peer becomes I, the requester becomes M and memory stays stale. A store or atomic from I sends a read-invalidate and leaves the requester in M with memory stale.
- R6: A store or atomic to an E line moves it to M with no message and marks memory stale. The same request to an M line sends nothing and changes nothing.
- R7: A store or atomic to an S line sends an invalidate (kind 3) and invalidates every peer at once. The requester stays S and no other request is served until every other CPU's snoop_ack has been seen. The requester then becomes M, memory is marked stale and req_done is raised.
- R8: Evicting an M line sends a writeback (kind 4), makes the line I and marks memory current. Evicting an E or S line makes it I with no message and leaves memory unchanged.
- R9: At most one request completes per cycle. When several CPUs wait, they are served in cyclic order starting after the CPU served last (CPU 0 first after reset). req_done for a CPU is a one-cycle pulse in the cycle after its request is resolved.
- R10: No line is ever held in M or E by more than one cache. Memory is stale for a line exactly when one cache holds it in M.
- R11: A message appears on msg_valid/msg_kind/msg_src/msg_line for exactly one cycle, in the same cycle that the request's resolution becomes visible. msg_kind is 0 whenever msg_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCPU | Per-CPU request pending, held until req_done |
| req_op | input | 3*NCPU | Per-CPU op code, CPU c at bits [3c+2:3c] |
| req_line | input | LW*NCPU | Per-CPU line index, CPU c at bits [LW*c +: LW] |
| snoop_ack | input | NCPU | Per-CPU acknowledge of an invalidate |
| req_done | output | NCPU | One-cycle completion pulse per CPU |
| msg_valid | output | 1 | Bus message present this cycle |
| msg_kind | output | 3 | 1 read, 2 read-invalidate, 3 invalidate, 4 writeback |
| msg_line | output | LW | Line the message refers to |
| msg_src | output | CW | CPU that caused the message |
| line_state | output | 2*NCPU*NLINE | State of line l in CPU c at bits [2*(c*NLINE+l) +: 2] |
| mem_fresh | output | NLINE | 1 when memory holds current data for the line |

## Verification
The directed sequence walks one line through every state: shared by two readers, silently dropped, taken for ownership, dirtied, stolen by an atomic from the modified holder, and written back. This separates the message chosen for each starting state of the requester from the effect on peers. A second line is dirtied and then read by another CPU, which separates the downgrade-with-writeback path from a plain miss. A store to a doubly shared line is acknowledged one CPU at a time while another CPU waits, which shows that the state change and the blocking of other requests both depend on the last acknowledge. A burst of four simultaneous loads shows the cyclic grant order, and an evict of a clean exclusive line shows that memory is left untouched.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0, OP_LOADX = 3'd1, OP_STORE = 3'd2, OP_ATOMIC = 3'd3, OP_EVICT = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    MSG_NONE = 3'd0, MSG_READ = 3'd1, MSG_RDINV = 3'd2, MSG_INV = 3'd3, MSG_WB = 3'd4
  } msg_e;

  typedef enum logic [1:0] {PA_KEEP = 2'd0, PA_SHARE = 2'd1, PA_KILL = 2'd2} peer_e;
  typedef enum logic [1:0] {MA_KEEP = 2'd0, MA_FRESH = 2'd1, MA_STALE = 2'd2} mem_e;

  typedef struct packed {
    mesi_e req_next;
    peer_e peer;
    msg_e  msg;
    mem_e  mem;
    logic  wait_ack;
  } plan_t;

  // Decide the outcome of one request from the requester's own state
  // and whether some peer holds the line modified.
  function automatic plan_t resolve(mesi_e mine, op_e op, logic peer_mod);
    plan_t p;
    p.req_next = mine;
    p.peer     = PA_KEEP;
    p.msg      = MSG_NONE;
    p.mem      = MA_KEEP;
    p.wait_ack = 1'b0;
    unique case (op)
      OP_LOAD: begin
        if (mine == ST_I) begin
          p.msg      = MSG_READ;
          p.peer     = PA_SHARE;
          p.req_next = ST_S;
          p.mem      = MA_FRESH;
        end
      end
      OP_LOADX: begin
        if (mine == ST_I || mine == ST_S) begin
          p.msg      = MSG_RDINV;
          p.peer     = PA_KILL;
          p.req_next = peer_mod ? ST_M : ST_E;
          p.mem      = peer_mod ? MA_STALE : MA_KEEP;
        end
      end
      OP_STORE, OP_ATOMIC: begin
        unique case (mine)
          ST_E: begin
            p.req_next = ST_M;
            p.mem      = MA_STALE;
          end
          ST_S: begin
            p.msg      = MSG_INV;
            p.peer     = PA_KILL;
            p.wait_ack = 1'b1;
          end
          ST_I: begin
            p.msg      = MSG_RDINV;
            p.peer     = PA_KILL;
            p.req_next = ST_M;
            p.mem      = MA_STALE;
          end
          default: ;
        endcase
      end
      OP_EVICT: begin
        if (mine == ST_M) begin
          p.msg = MSG_WB;
          p.mem = MA_FRESH;
        end
        p.req_next = ST_I;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/mesi_rr_arbiter.sv
module mesi_rr_arbiter #(
  parameter int N = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [N-1:0]  req,
  output logic          gnt_valid,
  output logic [CW-1:0] gnt_idx
);
  logic [CW-1:0] last_q;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int off = 1; off <= N; off++) begin
      int t;
      t = int'(last_q) + off;
      if (t >= N) t = t - N;
      if (enable && !gnt_valid && req[t]) begin
        gnt_valid = 1'b1;
        gnt_idx   = CW'(t);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= CW'(N - 1);
    else if (gnt_valid) last_q <= gnt_idx;
  end
endmodule

// File: rtl/mesi_ack_track.sv
module mesi_ack_track #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] need_in,
  input  logic [N-1:0] ack,
  output logic         active,
  output logic         finish
);
  logic [N-1:0] need_q, seen_q, covered;
  logic         active_q;

  assign covered = seen_q | ack;
  assign active  = active_q;
  assign finish  = active_q && ((covered & need_q) == need_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      need_q   <= '0;
      seen_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      need_q   <= need_in;
      seen_q   <= '0;
    end else if (finish) begin
      active_q <= 1'b0;
      seen_q   <= '0;
    end else if (active_q) begin
      seen_q   <= covered;
    end
  end
endmodule

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NLINE = 4,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int LW = (NLINE > 1) ? $clog2(NLINE) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CW-1:0]           wr_cpu,
  input  logic [LW-1:0]           wr_line,
  input  mesi_e                   wr_state,
  input  peer_e                   wr_peer,
  input  mem_e                    wr_mem,
  output mesi_e                   st_o [NCPU][NLINE],
  output logic [NCPU*NLINE*2-1:0] flat_o,
  output logic [NLINE-1:0]        fresh_o
);
  mesi_e           st_q [NCPU][NLINE];
  logic [NLINE-1:0] fresh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++)
        for (int l = 0; l < NLINE; l++)
          st_q[c][l] <= ST_I;
      fresh_q <= '1;
    end else if (wr_en) begin
      for (int c = 0; c < NCPU; c++) begin
        if (CW'(c) == wr_cpu) begin
          st_q[c][wr_line] <= wr_state;
        end else begin
          unique case (wr_peer)
            PA_SHARE: if (st_q[c][wr_line] != ST_I) st_q[c][wr_line] <= ST_S;
            PA_KILL:  st_q[c][wr_line] <= ST_I;
            default:  ;
          endcase
        end
      end
      if (wr_mem == MA_FRESH) fresh_q[wr_line] <= 1'b1;
      else if (wr_mem == MA_STALE) fresh_q[wr_line] <= 1'b0;
    end
  end

  assign st_o    = st_q;
  assign fresh_o = fresh_q;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar l = 0; l < NLINE; l++) begin : g_line
      assign flat_o[(c*NLINE+l)*2 +: 2] = st_q[c][l];
    end
  end
endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NLINE = 4,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int LW = (NLINE > 1) ? $clog2(NLINE) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCPU-1:0]         req_valid,
  input  logic [NCPU*3-1:0]       req_op,
  input  logic [NCPU*LW-1:0]      req_line,
  input  logic [NCPU-1:0]         snoop_ack,
  output logic [NCPU-1:0]         req_done,
  output logic                    msg_valid,
  output logic [2:0]              msg_kind,
  output logic [LW-1:0]           msg_line,
  output logic [CW-1:0]           msg_src,
  output logic [NCPU*NLINE*2-1:0] line_state,
  output logic [NLINE-1:0]        mem_fresh
);
  // Named internal events, visible to the bound checker.
  logic          busy;
  logic          grant_fire;
  logic          complete_fire;
  logic [CW-1:0] gnt_idx;
  op_e           sel_op;
  logic [LW-1:0] sel_line;
  logic          peer_mod;
  mesi_e         mine;
  plan_t         plan;
  mesi_e         st_view [NCPU][NLINE];
  logic [CW-1:0] wait_cpu_q;
  logic [LW-1:0] wait_line_q;
  logic [NCPU-1:0] need_mask;

  mesi_rr_arbiter #(.N(NCPU)) u_arb (
    .clk(clk), .rst_n(rst_n), .enable(!busy), .req(req_valid),
    .gnt_valid(grant_fire), .gnt_idx(gnt_idx)
  );

  assign sel_op   = op_e'(req_op[gnt_idx*3 +: 3]);
  assign sel_line = req_line[gnt_idx*LW +: LW];
  assign mine     = st_view[gnt_idx][sel_line];

  always_comb begin
    peer_mod  = 1'b0;
    need_mask = '1;
    for (int c = 0; c < NCPU; c++) begin
      if (CW'(c) != gnt_idx && st_view[c][sel_line] == ST_M) peer_mod = 1'b1;
      if (CW'(c) == gnt_idx) need_mask[c] = 1'b0;
    end
  end

  assign plan = resolve(mine, sel_op, peer_mod);

  mesi_ack_track #(.N(NCPU)) u_ack (
    .clk(clk), .rst_n(rst_n),
    .start(grant_fire && plan.wait_ack), .need_in(need_mask), .ack(snoop_ack),
    .active(busy), .finish(complete_fire)
  );

  // Either a fresh grant or the close of a pending invalidate writes the array.
  logic          wr_en;
  logic [CW-1:0] wr_cpu;
  logic [LW-1:0] wr_line;
  mesi_e         wr_state;
  peer_e         wr_peer;
  mem_e          wr_mem;

  always_comb begin
    wr_en    = grant_fire || complete_fire;
    wr_cpu   = gnt_idx;
    wr_line  = sel_line;
    wr_state = plan.req_next;
    wr_peer  = plan.peer;
    wr_mem   = plan.mem;
    if (complete_fire) begin
      wr_cpu   = wait_cpu_q;
      wr_line  = wait_line_q;
      wr_state = ST_M;
      wr_peer  = PA_KEEP;
      wr_mem   = MA_STALE;
    end
  end

  mesi_line_store #(.NCPU(NCPU), .NLINE(NLINE)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_line(wr_line),
    .wr_state(wr_state), .wr_peer(wr_peer), .wr_mem(wr_mem),
    .st_o(st_view), .flat_o(line_state), .fresh_o(mem_fresh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_done    <= '0;
      msg_valid   <= 1'b0;
      msg_kind    <= MSG_NONE;
      msg_line    <= '0;
      msg_src     <= '0;
      wait_cpu_q  <= '0;
      wait_line_q <= '0;
    end else begin
      req_done  <= '0;
      msg_valid <= 1'b0;
      msg_kind  <= MSG_NONE;
      if (grant_fire) begin
        if (plan.msg != MSG_NONE) begin
          msg_valid <= 1'b1;
          msg_kind  <= plan.msg;
          msg_line  <= sel_line;
          msg_src   <= gnt_idx;
        end
        if (plan.wait_ack) begin
          wait_cpu_q  <= gnt_idx;
          wait_line_q <= sel_line;
        end else begin
          req_done[gnt_idx] <= 1'b1;
        end
      end
      if (complete_fire) req_done[wait_cpu_q] <= 1'b1;
    end
  end
endmodule

// File: rtl/mesi_ctrl_chk.sv
module mesi_ctrl_chk #(
  parameter int NCPU  = 4,
  parameter int NLINE = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NCPU-1:0]         req_valid,
  input logic [NCPU-1:0]         req_done,
  input logic                    msg_valid,
  input logic [2:0]              msg_kind,
  input logic [NCPU*NLINE*2-1:0] line_state,
  input logic [NLINE-1:0]        mem_fresh,
  input logic                    busy,
  input logic                    grant_fire
);
  logic [NCPU-1:0] own_m [NLINE];
  logic [NCPU-1:0] own_any [NLINE];

  always_comb begin
    for (int l = 0; l < NLINE; l++) begin
      for (int c = 0; c < NCPU; c++) begin
        own_m[l][c]   = line_state[(c*NLINE+l)*2 +: 2] == 2'd3;
        own_any[l][c] = line_state[(c*NLINE+l)*2 +: 2] >= 2'd2;
      end
    end
  end

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    // R10
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(own_any[l]) <= 1);
    // R10
    stale_means_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_fresh[l] |-> $countones(own_m[l]) == 1);
    // R10
    fresh_means_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_fresh[l] |-> $countones(own_m[l]) == 0);
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    // R9
    done_had_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_done[c] |-> $past(req_valid[c]));
  end

  // R9
  one_done_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_done));

  // R7
  no_grant_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !grant_fire);

  // R11
  msg_kind_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_kind >= 3'd1 && msg_kind <= 3'd4));

  // R11
  msg_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> msg_kind == 3'd0);
endmodule

bind mesi_ctrl mesi_ctrl_chk #(.NCPU(NCPU), .NLINE(NLINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_done(req_done),
  .msg_valid(msg_valid), .msg_kind(msg_kind), .line_state(line_state),
  .mem_fresh(mem_fresh), .busy(busy), .grant_fire(grant_fire)
);

// File: tb/sim_mesi_ctrl.sv
module sim_mesi_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NL = 4;
  localparam int LW = 2;
  localparam int CW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC-1:0]     req_valid = '0;
  logic [NC*3-1:0]   req_op = '0;
  logic [NC*LW-1:0]  req_line = '0;
  logic [NC-1:0]     snoop_ack = '0;
  logic [NC-1:0]     req_done;
  logic              msg_valid;
  logic [2:0]        msg_kind;
  logic [LW-1:0]     msg_line;
  logic [CW-1:0]     msg_src;
  logic [NC*NL*2-1:0] line_state;
  logic [NL-1:0]     mem_fresh;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int got_kind, got_src, got_line;

  mesi_ctrl #(.NCPU(NC), .NLINE(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_line(req_line), .snoop_ack(snoop_ack), .req_done(req_done),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_line(msg_line),
    .msg_src(msg_src), .line_state(line_state), .mem_fresh(mem_fresh)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int st(int c, int l);
    return int'(line_state[(c*NL+l)*2 +: 2]);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Present one request and wait for its completion pulse; capture the message.
  task automatic issue(int c, int op, int l);
    bit seen = 0;
    @(negedge clk);
    req_op[c*3 +: 3]    = 3'(op);
    req_line[c*LW +: LW] = LW'(l);
    req_valid[c]        = 1'b1;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (req_done[c]) begin
        seen = 1;
        got_kind = msg_valid ? int'(msg_kind) : 0;
        got_src  = int'(msg_src);
        got_line = int'(msg_line);
        req_valid[c] = 1'b0;
      end
    end
    if (!seen) check("R9 request never completed", 0, 1);
  endtask

  task automatic t_reset();
    for (int c = 0; c < NC; c++)
      for (int l = 0; l < NL; l++)
        check("R1 reset state", st(c, l), 0);
    check("R1 reset memory flags", int'(mem_fresh), 4'hF);
    check("R1 reset done", int'(req_done), 0);
    check("R1 reset msg_valid", int'(msg_valid), 0);
  endtask

  task automatic t_shared_loads();
    issue(0, 0, 0);
    check("R2 read kind", got_kind, 1);
    check("R11 msg src", got_src, 0);
    check("R11 msg line", got_line, 0);
    check("R2 cpu0 shared", st(0, 0), 1);
    check("R2 memory current", int'(mem_fresh[0]), 1);
    @(negedge clk);
    check("R11 message lasts one cycle", int'(msg_valid), 0);
    issue(3, 0, 0);
    check("R2 second read kind", got_kind, 1);
    check("R2 cpu0 still shared", st(0, 0), 1);
    check("R2 cpu3 shared", st(3, 0), 1);
    issue(3, 0, 0);
    check("R2 load hit no message", got_kind, 0);
    check("R2 load hit state", st(3, 0), 1);
  endtask

  task automatic t_evict_shared();
    issue(0, 4, 0);
    check("R8 evict shared no message", got_kind, 0);
    check("R8 evict shared cpu0 invalid", st(0, 0), 0);
    check("R8 evict shared cpu3 kept", st(3, 0), 1);
    check("R8 evict shared memory", int'(mem_fresh[0]), 1);
  endtask

  task automatic t_load_excl();
    issue(2, 1, 0);
    check("R4 read-invalidate kind", got_kind, 2);
    check("R4 cpu2 exclusive", st(2, 0), 2);
    check("R4 cpu3 invalidated", st(3, 0), 0);
    check("R4 memory unchanged", int'(mem_fresh[0]), 1);
  endtask

  task automatic t_store_excl();
    issue(2, 2, 0);
    check("R6 store on E no message", got_kind, 0);
    check("R6 store on E gives M", st(2, 0), 3);
    check("R6 memory stale", int'(mem_fresh[0]), 0);
    issue(2, 3, 0);
    check("R6 atomic on M no message", got_kind, 0);
    check("R6 atomic on M stays M", st(2, 0), 3);
  endtask

  task automatic t_atomic_steal();
    issue(1, 3, 0);
    check("R5 atomic read-invalidate", got_kind, 2);
    check("R5 cpu1 modified", st(1, 0), 3);
    check("R5 cpu2 invalidated", st(2, 0), 0);
    check("R5 memory still stale", int'(mem_fresh[0]), 0);
  endtask

  task automatic t_evict_mod();
    issue(1, 4, 0);
    check("R8 writeback kind", got_kind, 4);
    check("R8 cpu1 invalid", st(1, 0), 0);
    check("R8 memory current", int'(mem_fresh[0]), 1);
  endtask

  task automatic t_load_from_mod();
    issue(0, 2, 1);
    check("R5 store from I read-invalidate", got_kind, 2);
    check("R5 store from I gives M", st(0, 1), 3);
    check("R5 store from I memory stale", int'(mem_fresh[1]), 0);
    issue(3, 0, 1);
    check("R3 read kind", got_kind, 1);
    check("R3 owner downgraded", st(0, 1), 1);
    check("R3 requester shared", st(3, 1), 1);
    check("R3 memory current", int'(mem_fresh[1]), 1);
  endtask

  task automatic t_store_shared();
    @(negedge clk);
    req_op[3*3 +: 3]      = 3'd2;
    req_line[3*LW +: LW]  = 2'd1;
    req_valid[3]          = 1'b1;
    @(negedge clk);
    check("R7 invalidate kind", msg_valid ? int'(msg_kind) : 0, 3);
    check("R7 invalidate src", int'(msg_src), 3);
    check("R7 not done yet", int'(req_done), 0);
    check("R7 peer invalidated", st(0, 1), 0);
    check("R7 requester still shared", st(3, 1), 1);
    req_op[1*3 +: 3]     = 3'd0;
    req_line[1*LW +: LW] = 2'd2;
    req_valid[1]         = 1'b1;
    for (int a = 0; a < 2; a++) begin
      snoop_ack = 4'(1 << a);
      @(negedge clk);
      snoop_ack = '0;
      check("R7 partial acks keep S", st(3, 1), 1);
      check("R7 partial acks block others", int'(req_done), 0);
    end
    snoop_ack = 4'b0100;
    @(negedge clk);
    snoop_ack = '0;
    check("R7 last ack completes", int'(req_done), 4'b1000);
    check("R7 requester modified", st(3, 1), 3);
    check("R7 memory stale", int'(mem_fresh[1]), 0);
    req_valid[3] = 1'b0;
    @(negedge clk);
    check("R9 waiting CPU served after", int'(req_done), 4'b0010);
    check("R2 waiting load read kind", msg_valid ? int'(msg_kind) : 0, 1);
    req_valid[1] = 1'b0;
    check("R2 waiting load shared", st(1, 2), 1);
  endtask

  task automatic t_round_robin();
    int order [4] = '{2, 3, 0, 1};
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      req_op[c*3 +: 3]     = 3'd0;
      req_line[c*LW +: LW] = 2'd3;
    end
    req_valid = 4'hF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 cyclic grant order", int'(req_done), 1 << order[i]);
      req_valid = req_valid & ~req_done;
    end
    req_valid = '0;
    for (int c = 0; c < NC; c++) check("R2 burst loads shared", st(c, 3), 1);
  endtask

  task automatic t_evict_excl();
    issue(0, 1, 2);
    check("R4 from I with sharer", got_kind, 2);
    check("R4 exclusive", st(0, 2), 2);
    check("R4 sharer dropped", st(1, 2), 0);
    issue(0, 4, 2);
    check("R8 evict E no message", got_kind, 0);
    check("R8 evict E invalid", st(0, 2), 0);
    check("R8 evict E memory", int'(mem_fresh[2]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shared_loads();
    t_evict_shared();
    t_load_excl();
    t_store_excl();
    t_atomic_steal();
    t_evict_mod();
    t_load_from_mod();
    t_store_shared();
    t_round_robin();
    t_evict_excl();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finish_run();
  end
endmodule